// File: doc/BRIEF.md
# Conversion Start and Settling Sequencer

This block is the control core of a delta-sigma converter's digital side. It decides when conversions run, holds off the data-ready strobe until the decimation filter has settled after a start, and then paces data-ready at the output data period. It also sequences initialization after a reset, and it pulses a reset into the filter when certain configuration bytes change. The serial port, register file, modulator and filter datapath lie outside it. A down-counter stands in for each settling interval and each conversion period.

A conversion run is requested by the START pin or by a latched start command, combined by OR. The settle and period lengths follow from the 3-bit rate code. Single-shot mode produces one result per start. The active-low data-ready output stays low for a fixed number of clocks, or until the host signals that it has read the result.

Top module: `adc_conv_seq`

## Requirements
- R1: Holding `rst_pin_n` low (asynchronous), or a `cmd_reset` strobe sampled on a clock edge, puts the block in initialization. It also clears the start latch and restores the shadowed configuration bytes to their defaults. On the edge after `cmd_reset`, `drdy_n` is 1, `conv_active` is 0 and `filt_rst` is 0.
- R2: Initialization lasts INIT_CYCLES (default 18) rising edges after reset ends. Reset ends at the release of `rst_pin_n`, or at the edge that sampled `cmd_reset`. On the next edge after that, a pending run request starts settling and `conv_active` rises.
- R3: The settling length for rate code d is S(d) = SETTLE_UNIT·2^d + SETTLE_OFS clocks, which is 1160, 2312, 4616, 9224, 18440, 36872 or 73736 for codes 0 to 6 at the default values. Code 7 is treated as code 6. The first falling edge of `drdy_n` comes S(d) edges after the edge that began settling.
- R4: The run request is `start_pin` OR a latch. `cmd_start` sets the latch and `cmd_stop` clears it, and stop wins when both arrive together. When the request is low during conversion, `conv_active` and `drdy_n` are inactive from the next edge, and no further data-ready occurs.
- R5: In continuous mode (`cfg_single`=0), each later `drdy_n` fall follows the previous one by P(d) = PERIOD_UNIT·2^d clocks (default 1024·2^d).
- R6: In single-shot mode (`cfg_single`=1), exactly one data-ready follows a start. `conv_active` then stays low until a rising edge of `start_pin` or a `cmd_start` occurs.
- R7: After it falls, `drdy_n` stays low for DRDY_PULSE (default 4) clocks. If `data_read` is sampled high earlier, it returns high on that edge instead.
- R8: A write (`wr_en`) to RATE_ADDR (default 1) or RESP_ADDR (default 9) whose data differs from the shadowed byte raises `filt_rst` for one cycle, on the edge after the write. The shadow defaults are 0x06 and 0x20. A write of an equal value, or a write to any other address, gives no pulse.
- R9: If `filt_rst` is sampled high while converting, settling restarts on that edge with the current rate code, and `drdy_n` is forced high.
- R10: A rising edge of `start_pin`, or a `cmd_start`, while converting restarts settling on the edge that samples it, and `drdy_n` is forced high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_pin_n | input | 1 | Active-low asynchronous reset pin |
| start_pin | input | 1 | START pin, level requests conversion |
| cmd_reset | input | 1 | Decoded reset command strobe |
| cmd_start | input | 1 | Decoded start command strobe |
| cmd_stop | input | 1 | Decoded stop command strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| cfg_rate | input | 3 | Data-rate code from the register file |
| cfg_single | input | 1 | 1 selects single-shot mode |
| data_read | input | 1 | Host has read the current result |
| drdy_n | output | 1 | Active-low data ready |
| filt_rst | output | 1 | One-cycle reset pulse to the decimation filter |
| conv_active | output | 1 | Settling or converting |

## Verification
Assertions check the following on every cycle:
- data-ready never falls unless a conversion was in progress;
- a dropped run request silences the outputs on the next edge;
- the low time of data-ready never exceeds its pulse length;
- every filter reset is preceded by a write;
- a reset command or a start edge leaves data-ready inactive.

Only the bench scenarios can show the exact cycle counts. These are the initialization length, the settle length per rate code including the clamped code 7, the period spacing, the one-shot count, and the restart timing after a filter-reset write.

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int INIT_CYCLES = 18,
  parameter int SETTLE_UNIT = 1152,
  parameter int SETTLE_OFS  = 8,
  parameter int PERIOD_UNIT = 1024,
  parameter int DRDY_PULSE  = 4,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter logic [ADDR_W-1:0] RATE_ADDR = 1,
  parameter logic [ADDR_W-1:0] RESP_ADDR = 9,
  parameter logic [DATA_W-1:0] RATE_DFLT = 8'h06,
  parameter logic [DATA_W-1:0] RESP_DFLT = 8'h20
) (
  input  logic              clk,
  input  logic              rst_pin_n,
  input  logic              start_pin,
  input  logic              cmd_reset,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        cfg_rate,
  input  logic              cfg_single,
  input  logic              data_read,
  output logic              drdy_n,
  output logic              filt_rst,
  output logic              conv_active
);

  localparam int SETTLE_MAX = SETTLE_UNIT * 64 + SETTLE_OFS;
  localparam int PERIOD_MAX = PERIOD_UNIT * 64;
  localparam int MAX_T      = (SETTLE_MAX > PERIOD_MAX) ? SETTLE_MAX : PERIOD_MAX;
  localparam int CNT_W      = $clog2(MAX_T + 1);
  localparam int INIT_W     = $clog2(INIT_CYCLES + 1);
  localparam int PULSE_W    = $clog2(DRDY_PULSE + 1);

  typedef enum logic [2:0] {S_INIT, S_IDLE, S_SETTLE, S_RUN, S_HALT} state_t;

  state_t              state;
  logic [INIT_W-1:0]   init_cnt;
  logic [CNT_W-1:0]    tcnt;
  logic [PULSE_W-1:0]  pulse_cnt;
  logic                start_lat, pin_q;
  logic [DATA_W-1:0]   rate_shadow, resp_shadow;

  logic [2:0]       rate_eff;
  logic [CNT_W-1:0] settle_len, period_len;
  logic             lat_nxt, run_req, start_evt, wr_hit, converting;

  assign rate_eff   = (cfg_rate == 3'd7) ? 3'd6 : cfg_rate;
  assign settle_len = CNT_W'(SETTLE_UNIT * (1 << rate_eff) + SETTLE_OFS);
  assign period_len = CNT_W'(PERIOD_UNIT * (1 << rate_eff));

  assign lat_nxt   = cmd_stop ? 1'b0 : (cmd_start ? 1'b1 : start_lat);
  assign run_req   = start_pin | lat_nxt;
  assign start_evt = (start_pin & ~pin_q) | (cmd_start & ~cmd_stop);
  assign wr_hit    = wr_en & (((wr_addr == RATE_ADDR) && (wr_data != rate_shadow)) ||
                              ((wr_addr == RESP_ADDR) && (wr_data != resp_shadow)));

  assign converting  = (state == S_SETTLE) || (state == S_RUN);
  assign conv_active = converting;
  assign drdy_n      = (pulse_cnt == '0);

  always_ff @(posedge clk or negedge rst_pin_n) begin
    if (!rst_pin_n) begin
      state       <= S_INIT;
      init_cnt    <= '0;
      tcnt        <= '0;
      pulse_cnt   <= '0;
      start_lat   <= 1'b0;
      pin_q       <= 1'b0;
      filt_rst    <= 1'b0;
      rate_shadow <= RATE_DFLT;
      resp_shadow <= RESP_DFLT;
    end else if (cmd_reset) begin
      state       <= S_INIT;
      init_cnt    <= '0;
      tcnt        <= '0;
      pulse_cnt   <= '0;
      start_lat   <= 1'b0;
      pin_q       <= start_pin;
      filt_rst    <= 1'b0;
      rate_shadow <= RATE_DFLT;
      resp_shadow <= RESP_DFLT;
    end else begin
      pin_q     <= start_pin;
      filt_rst  <= wr_hit;
      start_lat <= lat_nxt;
      if (wr_en && wr_addr == RATE_ADDR) rate_shadow <= wr_data;
      if (wr_en && wr_addr == RESP_ADDR) resp_shadow <= wr_data;
      if (pulse_cnt != '0) pulse_cnt <= data_read ? '0 : pulse_cnt - 1'b1;

      case (state)
        S_INIT:
          if (init_cnt == INIT_W'(INIT_CYCLES - 1)) state <= S_IDLE;
          else init_cnt <= init_cnt + 1'b1;
        S_IDLE:
          if (run_req) begin
            state     <= S_SETTLE;
            tcnt      <= settle_len - 1'b1;
            pulse_cnt <= '0;
          end
        S_SETTLE, S_RUN:
          if (!run_req) begin
            state     <= S_IDLE;
            pulse_cnt <= '0;
          end else if (start_evt || filt_rst) begin
            state     <= S_SETTLE;
            tcnt      <= settle_len - 1'b1;
            pulse_cnt <= '0;
          end else if (tcnt == '0) begin
            pulse_cnt <= PULSE_W'(DRDY_PULSE);
            if (cfg_single) begin
              state     <= S_HALT;
              start_lat <= 1'b0;
            end else begin
              state <= S_RUN;
              tcnt  <= period_len - 1'b1;
            end
          end else begin
            tcnt <= tcnt - 1'b1;
          end
        S_HALT:
          if (!run_req) state <= S_IDLE;
          else if (start_evt) begin
            state     <= S_SETTLE;
            tcnt      <= settle_len - 1'b1;
            pulse_cnt <= '0;
          end
        default: state <= S_INIT;
      endcase
    end
  end

  logic [PULSE_W:0] low_run;
  always_ff @(posedge clk or negedge rst_pin_n) begin
    if (!rst_pin_n) low_run <= '0;
    else if (drdy_n) low_run <= '0;
    else if (low_run <= (PULSE_W+1)'(DRDY_PULSE)) low_run <= low_run + 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_pin_n)
    cmd_reset |=> (drdy_n && !conv_active && !filt_rst));

  p_drdy_needs_conv_r3: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $fell(drdy_n) |-> $past(conv_active));

  p_rise_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $rose(conv_active) |-> $past(run_req));

  p_stop_quiet_r4: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (conv_active && !run_req) |=> (drdy_n && !conv_active));

  p_pulse_width_r7: assert property (@(posedge clk) disable iff (!rst_pin_n)
    low_run <= (PULSE_W+1)'(DRDY_PULSE));

  p_filt_after_write_r8: assert property (@(posedge clk) disable iff (!rst_pin_n)
    filt_rst |-> $past(wr_en));

  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (conv_active && run_req && start_evt && !cmd_reset) |=> (drdy_n && conv_active));

endmodule

// File: tb/adc_conv_seq_tb_top.sv
module adc_conv_seq_tb_top;
  localparam int SU = 36, SO = 8, PU = 32, PW = 4;

  logic clk = 1'b0;
  logic rst_pin_n, start_pin, cmd_reset, cmd_start, cmd_stop, wr_en, cfg_single, data_read;
  logic [7:0] wr_addr, wr_data;
  logic [2:0] cfg_rate;
  logic drdy_n, filt_rst, conv_active;

  adc_conv_seq #(.INIT_CYCLES(18), .SETTLE_UNIT(SU), .SETTLE_OFS(SO),
                 .PERIOD_UNIT(PU), .DRDY_PULSE(PW)) dut_i (
    .clk(clk), .rst_pin_n(rst_pin_n), .start_pin(start_pin), .cmd_reset(cmd_reset),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg_rate(cfg_rate), .cfg_single(cfg_single), .data_read(data_read),
    .drdy_n(drdy_n), .filt_rst(filt_rst), .conv_active(conv_active));

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  int exp_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int settle(input int d);
    int e = (d == 7) ? 6 : d;
    return SU * (1 << e) + SO;
  endfunction

  function automatic int period(input int d);
    int e = (d == 7) ? 6 : d;
    return PU * (1 << e);
  endfunction

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic drain(input string tag);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    exp_q.delete();
  endtask

  // Monitor: every falling edge of drdy_n is matched against the scoreboard queue
  logic prev_drdy = 1'b1;
  always @(negedge clk) begin
    if (prev_drdy && !drdy_n) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected DRDY", cyc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(cyc == e, "R3/R5 DRDY fall cycle", cyc, e);
      end
    end
    prev_drdy = drdy_n;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      chk(1'b0, "watchdog", cyc, -1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n0, f, c, g, r;
    rst_pin_n = 0; start_pin = 1; cmd_reset = 0; cmd_start = 0; cmd_stop = 0;
    wr_en = 0; wr_addr = 0; wr_data = 0; cfg_rate = 0; cfg_single = 0; data_read = 0;
    repeat (3) @(negedge clk);
    chk(drdy_n == 1'b1, "R1 drdy_n in reset", drdy_n, 1);
    chk(conv_active == 1'b0, "R1 conv_active in reset", conv_active, 0);
    chk(filt_rst == 1'b0, "R1 filt_rst in reset", filt_rst, 0);

    // R2/R3/R5: continuous after init with pin high, rate 0
    n0 = cyc;
    rst_pin_n = 1;
    f = n0 + 19 + settle(0);
    exp_q.push_back(f); exp_q.push_back(f + period(0)); exp_q.push_back(f + 2 * period(0));
    wait_to(n0 + 18);
    chk(conv_active == 1'b0, "R2 still initializing", conv_active, 0);
    wait_to(n0 + 19);
    chk(conv_active == 1'b1, "R2 settling begins", conv_active, 1);
    wait_to(f + 3);
    chk(drdy_n == 1'b0, "R7 low through pulse", drdy_n, 0);
    wait_to(f + 4);
    chk(drdy_n == 1'b1, "R7 high after pulse", drdy_n, 1);
    wait_to(f + 2 * period(0) + 2);
    start_pin = 0;
    wait_to(f + 3 * period(0) + 30);
    chk(drdy_n == 1'b1 && conv_active == 1'b0, "R4 stopped by pin", conv_active, 0);
    drain("R5 missing DRDY (scenario 1)");

    // R4/R7: command start, rate 1, early data read, command stop
    cfg_rate = 1;
    @(negedge clk); c = cyc;
    cmd_start = 1;
    f = c + 1 + settle(1);
    exp_q.push_back(f); exp_q.push_back(f + period(1));
    @(negedge clk); cmd_start = 0;
    wait_to(f + 1);
    data_read = 1;
    @(negedge clk); data_read = 0;
    chk(drdy_n == 1'b1, "R7 data read ends pulse", drdy_n, 1);
    wait_to(f + period(1) + 2);
    cmd_stop = 1;
    @(negedge clk); cmd_stop = 0;
    chk(conv_active == 1'b0, "R4 stopped by command", conv_active, 0);
    wait_to(f + 3 * period(1));
    drain("R4 missing DRDY (scenario 2)");

    // R6: single-shot via pin, then via command
    cfg_rate = 0; cfg_single = 1;
    @(negedge clk); c = cyc;
    start_pin = 1;
    f = c + 1 + settle(0);
    exp_q.push_back(f);
    wait_to(f + 3 * period(0));
    chk(conv_active == 1'b0, "R6 halted after one result", conv_active, 0);
    start_pin = 0;
    @(negedge clk); c = cyc;
    cmd_start = 1;
    f = c + 1 + settle(0);
    exp_q.push_back(f);
    @(negedge clk); cmd_start = 0;
    wait_to(f + 3);
    chk(drdy_n == 1'b0, "R7 one-shot pulse kept", drdy_n, 0);
    wait_to(f + 4 * period(0));
    chk(conv_active == 1'b0, "R6 command one-shot halted", conv_active, 0);
    drain("R6 missing DRDY (scenario 3)");

    // R8/R9: filter reset on changed rate byte restarts settling
    cfg_single = 0;
    @(negedge clk); c = cyc;
    start_pin = 1;
    f = c + 1 + settle(0);
    exp_q.push_back(f);
    wait_to(f + 1);
    wr_en = 1; wr_addr = 8'd1; wr_data = 8'h01; cfg_rate = 1;
    @(negedge clk); wr_en = 0;
    chk(filt_rst == 1'b1, "R8 pulse on changed rate byte", filt_rst, 1);
    @(negedge clk);
    chk(filt_rst == 1'b0, "R8 pulse lasts one cycle", filt_rst, 0);
    chk(drdy_n == 1'b1 && conv_active == 1'b1, "R9 restart forces drdy high", drdy_n, 1);
    f = f + 3 + settle(1);
    exp_q.push_back(f); exp_q.push_back(f + period(1)); exp_q.push_back(f + 2 * period(1));
    wait_to(f + period(1) + 3);
    g = cyc;
    wr_en = 1; wr_addr = 8'd1; wr_data = 8'h01;
    @(negedge clk); chk(filt_rst == 1'b0, "R8 equal rate value no pulse", filt_rst, 0);
    wr_addr = 8'd9; wr_data = 8'h20;
    @(negedge clk); chk(filt_rst == 1'b0, "R8 equal resp value no pulse", filt_rst, 0);
    wr_addr = 8'd5; wr_data = 8'hFF;
    @(negedge clk); chk(filt_rst == 1'b0, "R8 other address no pulse", filt_rst, 0);
    wr_en = 0;
    @(negedge clk); chk(filt_rst == 1'b0 && cyc == g + 4, "R8 quiet after writes", filt_rst, 0);
    wait_to(f + 2 * period(1) + 2);
    start_pin = 0;
    wait_to(f + 4 * period(1));
    drain("R9 missing DRDY (scenario 4)");

    // R10/R1/R2: start edge restart, then reset command
    cfg_rate = 0;
    @(negedge clk); c = cyc;
    start_pin = 1;
    f = c + 1 + settle(0);
    exp_q.push_back(f);
    wait_to(f + 10);
    cmd_start = 1;
    @(negedge clk); cmd_start = 0;
    chk(conv_active == 1'b1 && drdy_n == 1'b1, "R10 restart on start command", conv_active, 1);
    f = f + 11 + settle(0);
    exp_q.push_back(f);
    wait_to(f + 5);
    r = cyc;
    cmd_reset = 1;
    @(negedge clk); cmd_reset = 0;
    chk(conv_active == 1'b0 && drdy_n == 1'b1, "R1 reset command idles", conv_active, 0);
    exp_q.push_back(r + 20 + settle(0));
    wait_to(r + 19);
    chk(conv_active == 1'b0, "R2 init after command", conv_active, 0);
    wait_to(r + 20);
    chk(conv_active == 1'b1, "R2 settling after command init", conv_active, 1);
    wait_to(r + 20 + settle(0) + 10);
    start_pin = 0;
    wait_to(cyc + 100);
    drain("R2 missing DRDY (scenario 5)");

    // R3: code 7 clamps to code 6
    cfg_rate = 7;
    @(negedge clk); c = cyc;
    cmd_start = 1;
    exp_q.push_back(c + 1 + settle(7));
    @(negedge clk); cmd_start = 0;
    wait_to(c + 1 + settle(7) + 3);
    cmd_stop = 1;
    @(negedge clk); cmd_stop = 0;
    wait_to(cyc + 100);
    drain("R3 missing DRDY (code 7)");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule